// File: doc/BRIEF.md
# Host Interrupt Line Driver

This block turns short interrupt request strobes from on-chip logic into the interrupt lines seen by an external host processor. It serves two request channels. Each channel can signal the host either with a timed pulse or with a level that stays high until local logic clears it. The choice is shared by both channels and set by static configuration inputs.

A free-running divider turns the system clock into a tick enable, nominally 4 MHz. Pulse lengths are whole numbers of ticks: 1, 2, 4 or 8, which gives 250 ns to 2000 ns at the nominal tick rate. The second channel either drives its own pin or is ORed onto the first pin. Both pins are active high and come straight from flip-flops.

In pulse mode, a request that arrives while that channel's pulse is waiting for its first tick or is still running is absorbed into that pulse. With the longer widths this can hide an event from the host, which is why level signalling exists.

Top module: `host_irq_out`

## Requirements
- R1: After reset, both interrupt pins `irq0_o` and `irq1_o` are low.
- R2: In pulse mode (`cfg_level`=0), `cfg_width` codes 0, 1, 2 and 3 give a pin pulse of exactly 1, 2, 4 or 8 ticks, that is N×`TICK_DIV` clock cycles.
- R3: A pulse starts at the first tick strictly after the clock edge that samples the request. The pin rises one cycle after that tick, so it is first seen high between 2 and `TICK_DIV`+1 cycles after the sampling edge.
- R4: In pulse mode, a request on a channel whose pulse is pending or active produces no second pulse and does not lengthen the current one. A request made after the pulse has ended produces a new pulse.
- R5: In level mode (`cfg_level`=1), a request makes the pin high two clock edges after it is sampled. The pin stays high until a clear strobe for that channel. A clear sampled without a request on that channel drops the channel's level state, and the pin goes low two edges later.
- R6: In level mode, a request and a clear for the same channel in the same cycle leave the channel asserted.
- R7: With `cfg_split`=0, channel 1 activity appears on `irq0_o` (ORed with channel 0) and `irq1_o` stays low.
- R8: With `cfg_split`=1, channel 1 drives only `irq1_o` and channel 0 drives only `irq0_o`.
- R9: In pulse mode, clear strobes have no effect on a pulse.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 1 | 0 = pulse signalling, 1 = level signalling |
| cfg_width | input | 2 | Pulse length code: 1, 2, 4 or 8 ticks |
| cfg_split | input | 1 | 0 = channel 1 merged onto `irq0_o`, 1 = own pin |
| req0 | input | 1 | Request strobe, channel 0 |
| req1 | input | 1 | Request strobe, channel 1 |
| clr0 | input | 1 | Level clear strobe, channel 0 |
| clr1 | input | 1 | Level clear strobe, channel 1 |
| irq0_o | output | 1 | Interrupt pin 0, active high, registered |
| irq1_o | output | 1 | Interrupt pin 1, active high, registered |

## Verification
The bench builds the block with `TICK_DIV`=3, so one tick is three clock cycles. At that setting even the 8-tick pulse lasts only 24 cycles. This makes it practical to measure every width code exactly, to land a second request inside a running pulse, and to see the 2-to-4-cycle start window of a pulse at each end. A divider this short also lines requests up against tick edges in several different phases during the run.

// File: rtl/host_irq_out.sv
module host_irq_out #(
  parameter int TICK_DIV = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_level,
  input  logic [1:0] cfg_width,
  input  logic       cfg_split,
  input  logic       req0,
  input  logic       req1,
  input  logic       clr0,
  input  logic       clr1,
  output logic       irq0_o,
  output logic       irq1_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          tick;
  logic [1:0]    req, clr, pend, act, lvl, drive;
  logic [2:0]    left [2];
  logic [2:0]    span;

  assign tick  = (div_q == DW'(TICK_DIV - 1));
  assign req   = {req1, req0};
  assign clr   = {clr1, clr0};
  assign span  = (3'd1 << cfg_width) - 3'd1;
  assign drive = lvl | act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
      lvl  <= '0;
      for (int c = 0; c < 2; c++) left[c] <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (cfg_level) begin
          pend[c] <= 1'b0;
          act[c]  <= 1'b0;
          if (req[c])      lvl[c] <= 1'b1;
          else if (clr[c]) lvl[c] <= 1'b0;
        end else begin
          lvl[c] <= 1'b0;
          if (act[c]) begin
            if (tick) begin
              if (left[c] == 3'd0) act[c] <= 1'b0;
              else                 left[c] <= left[c] - 3'd1;
            end
          end else if (pend[c]) begin
            if (tick) begin
              pend[c] <= 1'b0;
              act[c]  <= 1'b1;
              left[c] <= span;
            end
          end else if (req[c]) begin
            pend[c] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
    end else begin
      irq0_o <= drive[0] | (~cfg_split & drive[1]);
      irq1_o <= cfg_split & drive[1];
    end
endmodule

module host_irq_out_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_level,
  input logic       cfg_split,
  input logic       req0,
  input logic       clr0,
  input logic       irq0_o,
  input logic       irq1_o,
  input logic       tick,
  input logic [1:0] act,
  input logic [1:0] lvl
);
  // R7
  merged_pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_split |=> !irq1_o);

  // R5
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_level && req0 |=> ##1 irq0_o);

  // R5
  level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_level && clr0 && !req0 |=> !lvl[0]);

  // R3
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act[0]) |-> $past(tick));

  // R3
  pulse1_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act[1]) |-> $past(tick));
endmodule

bind host_irq_out host_irq_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_split(cfg_split),
  .req0(req0), .clr0(clr0), .irq0_o(irq0_o), .irq1_o(irq1_o),
  .tick(tick), .act(act), .lvl(lvl)
);

// File: tb/test_host_irq_out.sv
module test_host_irq_out;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_level = 1'b0, cfg_split = 1'b0;
  logic [1:0] cfg_width = 2'd0;
  logic req0 = 1'b0, req1 = 1'b0, clr0 = 1'b0, clr1 = 1'b0;
  logic irq0_o, irq1_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  host_irq_out #(.TICK_DIV(D)) i_host_irq_out (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_width(cfg_width),
    .cfg_split(cfg_split), .req0(req0), .req1(req1), .clr0(clr0), .clr1(clr1),
    .irq0_o(irq0_o), .irq1_o(irq1_o));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // request on channel ch at step 0, optional extra request / clear at given steps
  task automatic run_pulse(input int ch, input int again_at, input int clr_at,
                           output int hi0, output int hi1, output int rise0,
                           output int rise1, output int first0, output int first1);
    logic p0 = 1'b0, p1 = 1'b0;
    hi0 = 0; hi1 = 0; rise0 = 0; rise1 = 0; first0 = -1; first1 = -1;
    @(negedge clk);
    if (ch == 0) req0 = 1'b1; else req1 = 1'b1;
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (ch == 0) begin req0 = (i == again_at); clr0 = (i == clr_at); end
      else         begin req1 = (i == again_at); clr1 = (i == clr_at); end
      if (irq0_o) begin hi0++; if (first0 < 0) first0 = i; end
      if (irq1_o) begin hi1++; if (first1 < 0) first1 = i; end
      if (irq0_o && !p0) rise0++;
      if (irq1_o && !p1) rise1++;
      p0 = irq0_o; p1 = irq1_o;
    end
    req0 = 0; req1 = 0; clr0 = 0; clr1 = 0;
  endtask

  task automatic t_reset();
    chk("R1 irq0 after reset", irq0_o, 0);
    chk("R1 irq1 after reset", irq1_o, 0);
  endtask

  task automatic t_widths();
    int h0, h1, r0, r1, f0, f1;
    cfg_level = 0; cfg_split = 1;
    for (int w = 0; w < 4; w++) begin
      cfg_width = 2'(w);
      run_pulse(0, -1, -1, h0, h1, r0, r1, f0, f1);
      chk($sformatf("R2 width code %0d length", w), h0, (1 << w) * D);
      chk($sformatf("R2 width code %0d single pulse", w), r0, 1);
      chk_rng($sformatf("R3 width code %0d start", w), f0, 3, D + 2);
    end
  endtask

  task automatic t_absorb();
    int h0, h1, r0, r1, f0, f1;
    cfg_level = 0; cfg_split = 1; cfg_width = 2'd3;
    run_pulse(0, 8, -1, h0, h1, r0, r1, f0, f1);
    chk("R4 absorbed request pulse count", r0, 1);
    chk("R4 absorbed request length", h0, 8 * D);
    run_pulse(0, 2, -1, h0, h1, r0, r1, f0, f1);
    chk("R4 request while pending count", r0, 1);
    chk("R4 request while pending length", h0, 8 * D);
    cfg_width = 2'd0;
    run_pulse(0, 30, -1, h0, h1, r0, r1, f0, f1);
    chk("R4 later request new pulse", r0, 2);
    chk("R4 later request total length", h0, 2 * D);
  endtask

  task automatic t_pulse_clear();
    int h0, h1, r0, r1, f0, f1;
    cfg_level = 0; cfg_split = 1; cfg_width = 2'd2;
    run_pulse(0, -1, 6, h0, h1, r0, r1, f0, f1);
    chk("R9 clear during pulse length", h0, 4 * D);
    chk("R9 clear during pulse count", r0, 1);
  endtask

  task automatic t_merge();
    int h0, h1, r0, r1, f0, f1;
    cfg_level = 0; cfg_split = 0; cfg_width = 2'd1;
    run_pulse(1, -1, -1, h0, h1, r0, r1, f0, f1);
    chk("R7 ch1 merged onto pin0 length", h0, 2 * D);
    chk("R7 pin1 idle when merged", h1, 0);
    cfg_split = 1;
    run_pulse(1, -1, -1, h0, h1, r0, r1, f0, f1);
    chk("R8 ch1 own pin length", h1, 2 * D);
    chk("R8 pin0 idle for ch1", h0, 0);
    run_pulse(0, -1, -1, h0, h1, r0, r1, f0, f1);
    chk("R8 ch0 pin0 length", h0, 2 * D);
    chk("R8 pin1 idle for ch0", h1, 0);
  endtask

  task automatic t_level();
    cfg_level = 1; cfg_split = 1;
    @(negedge clk); req0 = 1;
    @(negedge clk); req0 = 0;
    chk("R5 level pin after one edge", irq0_o, 0);
    @(negedge clk);
    chk("R5 level pin after two edges", irq0_o, 1);
    repeat (40) @(negedge clk);
    chk("R5 level held without clear", irq0_o, 1);
    clr0 = 1;
    @(negedge clk); clr0 = 0;
    chk("R5 level held one edge after clear", irq0_o, 1);
    @(negedge clk);
    chk("R5 level dropped after clear", irq0_o, 0);
    req0 = 1; clr0 = 1;
    @(negedge clk); req0 = 0; clr0 = 0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 request wins over clear", irq0_o, 1);
    cfg_split = 0;
    @(negedge clk); req1 = 1;
    @(negedge clk); req1 = 0; clr0 = 1;
    @(negedge clk); clr0 = 0;
    repeat (2) @(negedge clk);
    chk("R7 level ch1 merged holds pin0", irq0_o, 1);
    chk("R7 level pin1 idle when merged", irq1_o, 0);
    clr1 = 1;
    @(negedge clk); clr1 = 0;
    repeat (2) @(negedge clk);
    chk("R5 both cleared pin0 low", irq0_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_widths();
    t_absorb();
    t_pulse_clear();
    t_merge();
    t_level();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule